// File: doc/BRIEF.md
# Four-Channel DMA Priority Arbiter

This block decides which of several DMA request lines owns the system bus next. Each request is qualified by its channel's mask bit and by a controller-wide disable bit. When any qualified request is present, the arbiter raises a bus hold request to the processor. It then waits for the hold acknowledge. The winner is picked in the cycle the acknowledge is seen. That winner keeps a one-hot grant and an encoded channel number until the transfer logic signals that its service is complete.

Two priority orders are available, and a mode input selects between them at each evaluation. In fixed order the lowest channel number wins. In rotating order a pointer names the highest-priority channel. After every service in rotating order, the pointer moves to the channel just above the one that was served, wrapping around, so the served channel becomes the lowest. Any service completed in fixed order returns the pointer to channel 0. The channel count and the picker implementation are parameters.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, hold_req_o is 0, grant_o is all zeros and grant_id_o is 0, and the rotating pointer names channel 0 as highest.
- R2: From the idle state, hold_req_o rises one clock after a cycle in which some channel has req_i=1, mask_i=0 and ctrl_disable_i=0.
- R3: A channel whose mask_i bit is 1 is never granted, and masked requests alone never raise hold_req_o.
- R4: While ctrl_disable_i is 1, no hold request is raised from idle, whatever the requests and masks.
- R5: With rotate_i=0 at evaluation, the winner is the lowest-numbered eligible channel (0 highest, 3 lowest).
- R6: With rotate_i=1 at evaluation, eligible channels are scanned upward from the pointer, wrapping modulo the channel count. Completing a rotating service of channel k sets the pointer to k+1 modulo the count.
- R7: Evaluation happens in the cycle hlda_i is seen high while the hold request is pending. One clock later grant_o has exactly bit w set and grant_id_o equals w.
- R8: While a grant is held and svc_done_i is 0, grant_o and grant_id_o stay unchanged, whatever req_i, mask_i, ctrl_disable_i and rotate_i do.
- R9: A clock with svc_done_i=1 during a grant clears grant_o and hold_req_o at the next edge. No new hold request is raised until hlda_i has been seen low.
- R10: Completing a service with rotate_i=0 returns the pointer to channel 0. A change of rotate_i takes effect at the next evaluation.
- R11: In rotating mode, a channel that keeps requesting is granted after at most three services of other channels.
- R12: If no channel is eligible while the hold request is pending, hold_req_o drops at the next edge and no grant is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NCH | Request line per channel |
| mask_i | input | NCH | Per-channel mask, 1 blocks the channel |
| ctrl_disable_i | input | 1 | 1 blocks all new services |
| rotate_i | input | 1 | 1 selects rotating order, 0 fixed order |
| hlda_i | input | 1 | Bus hold acknowledge from the processor |
| svc_done_i | input | 1 | Current service has ended |
| hold_req_o | output | 1 | Bus hold request to the processor |
| grant_o | output | NCH | One-hot grant to the winning channel |
| grant_id_o | output | $clog2(NCH) | Encoded winning (or last served) channel |

## Verification
The assertions assume that hlda_i follows the handshake: it is raised only while hold_req_o is up, and it drops some time after the hold request falls. They also assume that svc_done_i is pulsed only during a grant. The sweep drives the acknowledge from its own handshake task, so it keeps within these rules. Requests and masks are changed freely during service to exercise the lock.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   typedef enum logic [1:0] {
      ARB_IDLE  = 2'd0,
      ARB_ASK   = 2'd1,
      ARB_SERVE = 2'd2,
      ARB_DRAIN = 2'd3
   } arb_state_e;

   // picker implementation choices
   localparam int PICK_SCAN    = 0;
   localparam int PICK_DOUBLED = 1;

   function automatic int wrap_sum(input int a, input int b, input int n);
      int s;
      s = a + b;
      if (s >= n) s = s - n;
      return s;
   endfunction

endpackage

// File: rtl/dma_arb_elig.sv
module dma_arb_elig #(
   parameter int NCH = 4
) (
   input  logic [NCH-1:0] req_i,
   input  logic [NCH-1:0] mask_i,
   input  logic           block_i,
   output logic [NCH-1:0] elig_o,
   output logic           any_o
);
   always_comb begin
      elig_o = block_i ? '0 : (req_i & ~mask_i);
      any_o  = |elig_o;
   end
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
   parameter int NCH   = 4,
   parameter int STYLE = dma_arb_pkg::PICK_SCAN,
   localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic [NCH-1:0] elig_i,
   input  logic [CW-1:0]  top_i,
   output logic [CW-1:0]  win_o,
   output logic           found_o
);
   import dma_arb_pkg::*;

   generate
      if (STYLE == PICK_SCAN) begin : g_scan
         always_comb begin
            int idx;
            win_o   = '0;
            found_o = 1'b0;
            for (int k = 0; k < NCH; k++) begin
               idx = wrap_sum(int'(top_i), k, NCH);
               if (!found_o && elig_i[CW'(idx)]) begin
                  found_o = 1'b1;
                  win_o   = CW'(idx);
               end
            end
         end
      end else begin : g_doubled
         logic [2*NCH-1:0] dbl;
         logic [NCH-1:0]   rot;
         always_comb begin
            int jsel;
            dbl  = {elig_i, elig_i} >> top_i;
            rot  = dbl[NCH-1:0];
            jsel = 0;
            for (int j = NCH - 1; j >= 0; j--) begin
               if (rot[j]) jsel = j;
            end
            found_o = |rot;
            win_o   = CW'(wrap_sum(int'(top_i), jsel, NCH));
         end
      end
   endgenerate
endmodule

// File: rtl/dma_arb_ptr.sv
module dma_arb_ptr #(
   parameter int NCH  = 4,
   localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd_i,
   input  logic          rotate_i,
   input  logic [CW-1:0] served_i,
   output logic [CW-1:0] top_o
);
   logic [CW-1:0] top_q;
   logic [CW-1:0] next_top;

   always_comb begin
      if (!rotate_i)
         next_top = '0;
      else if (served_i == CW'(NCH - 1))
         next_top = '0;
      else
         next_top = served_i + CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         top_q <= '0;
      else if (upd_i)
         top_q <= next_top;
   end

   assign top_o = top_q;
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
   parameter int NCH        = 4,
   parameter int PICK_STYLE = dma_arb_pkg::PICK_SCAN,
   localparam int CW        = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] req_i,
   input  logic [NCH-1:0] mask_i,
   input  logic           ctrl_disable_i,
   input  logic           rotate_i,
   input  logic           hlda_i,
   input  logic           svc_done_i,
   output logic           hold_req_o,
   output logic [NCH-1:0] grant_o,
   output logic [CW-1:0]  grant_id_o
);
   import dma_arb_pkg::*;

   generate
      if (NCH < 2 || NCH > 16) begin : g_bad_nch
         $error("dma_prio_arbiter: NCH must lie in 2..16");
      end
      if (PICK_STYLE != PICK_SCAN && PICK_STYLE != PICK_DOUBLED) begin : g_bad_style
         $error("dma_prio_arbiter: unknown PICK_STYLE");
      end
   endgenerate

   arb_state_e    state_q, state_d;
   logic          hold_q, hold_d;
   logic [NCH-1:0] grant_q, grant_d;
   logic [CW-1:0] id_q, id_d;
   logic          ptr_upd;

   logic [NCH-1:0] elig;
   logic           any_elig;
   logic [CW-1:0]  ptr_top;
   logic [CW-1:0]  eval_top;
   logic [CW-1:0]  win;
   logic           win_found;

   dma_arb_elig #(.NCH(NCH)) u_elig (
      .req_i   (req_i),
      .mask_i  (mask_i),
      .block_i (ctrl_disable_i),
      .elig_o  (elig),
      .any_o   (any_elig)
   );

   dma_arb_ptr #(.NCH(NCH)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_i    (ptr_upd),
      .rotate_i (rotate_i),
      .served_i (id_q),
      .top_o    (ptr_top)
   );

   // fixed order always scans from channel 0
   assign eval_top = rotate_i ? ptr_top : '0;

   dma_arb_pick #(.NCH(NCH), .STYLE(PICK_STYLE)) u_pick (
      .elig_i  (elig),
      .top_i   (eval_top),
      .win_o   (win),
      .found_o (win_found)
   );

   always_comb begin
      state_d = state_q;
      hold_d  = hold_q;
      grant_d = grant_q;
      id_d    = id_q;
      ptr_upd = 1'b0;
      unique case (state_q)
         ARB_IDLE: begin
            if (any_elig) begin
               state_d = ARB_ASK;
               hold_d  = 1'b1;
            end
         end
         ARB_ASK: begin
            if (!win_found) begin
               state_d = ARB_IDLE;
               hold_d  = 1'b0;
            end else if (hlda_i) begin
               state_d = ARB_SERVE;
               grant_d = NCH'(1) << win;
               id_d    = win;
            end
         end
         ARB_SERVE: begin
            if (svc_done_i) begin
               state_d = ARB_DRAIN;
               hold_d  = 1'b0;
               grant_d = '0;
               ptr_upd = 1'b1;
            end
         end
         ARB_DRAIN: begin
            if (!hlda_i) state_d = ARB_IDLE;
         end
         default: state_d = ARB_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ARB_IDLE;
         hold_q  <= 1'b0;
         grant_q <= '0;
         id_q    <= '0;
      end else begin
         state_q <= state_d;
         hold_q  <= hold_d;
         grant_q <= grant_d;
         id_q    <= id_d;
      end
   end

   assign hold_req_o = hold_q;
   assign grant_o    = grant_q;
   assign grant_id_o = id_q;
endmodule

// File: rtl/dma_prio_arbiter_chk.sv
module dma_prio_arbiter_chk #(
   parameter int NCH = 4,
   localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] req_i,
   input logic [NCH-1:0] mask_i,
   input logic           ctrl_disable_i,
   input logic           rotate_i,
   input logic           hlda_i,
   input logic           svc_done_i,
   input logic           hold_req_o,
   input logic [NCH-1:0] grant_o,
   input logic [CW-1:0]  grant_id_o
);
   // R7: grant is one-hot and agrees with the encoded id
   a_r7_onehot_id: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant_o) |-> ($onehot0(grant_o) && grant_o == (NCH'(1) << grant_id_o)));

   // R7: a grant only appears after an acknowledged hold request
   a_r7_grant_after_hlda: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|grant_o) |-> ($past(hlda_i) && $past(hold_req_o)));

   // R3: the granted channel was requesting and unmasked at evaluation
   a_r3_granted_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|grant_o) |-> (($past(req_i & ~mask_i) & grant_o) == grant_o));

   // R4: a new hold request needs an enabled, unmasked request
   a_r4_hold_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_req_o) |-> (!$past(ctrl_disable_i) && ($past(req_i & ~mask_i) != '0)));

   // R5: fixed order never passes over a lower eligible channel
   a_r5_fixed_order: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(|grant_o) && !$past(rotate_i)) |->
         (($past(req_i & ~mask_i) & (grant_o - NCH'(1))) == '0));

   // R8: the winner is locked until service completes
   a_r8_lock: assert property (@(posedge clk) disable iff (!rst_n)
      ((|grant_o) && !svc_done_i) |=> (grant_o == $past(grant_o) && hold_req_o));

   // R9: completion releases grant and hold together
   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      ((|grant_o) && svc_done_i) |=> (grant_o == '0 && !hold_req_o));

   // R12: pending hold with nothing eligible is withdrawn
   a_r12_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_req_o && !(|grant_o) && ((req_i & ~mask_i) == '0)) |=> !hold_req_o);
endmodule

bind dma_prio_arbiter dma_prio_arbiter_chk #(.NCH(NCH)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_i          (req_i),
   .mask_i         (mask_i),
   .ctrl_disable_i (ctrl_disable_i),
   .rotate_i       (rotate_i),
   .hlda_i         (hlda_i),
   .svc_done_i     (svc_done_i),
   .hold_req_o     (hold_req_o),
   .grant_o        (grant_o),
   .grant_id_o     (grant_id_o)
);

// File: tb/dma_prio_arbiter_test.sv
module dma_prio_arbiter_test;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;
   localparam int CW  = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] req_i = '0;
   logic [NCH-1:0] mask_i = '0;
   logic           ctrl_disable_i = 1'b0;
   logic           rotate_i = 1'b0;
   logic           hlda_i = 1'b0;
   logic           svc_done_i = 1'b0;
   logic           hold_req_o;
   logic [NCH-1:0] grant_o;
   logic [CW-1:0]  grant_id_o;

   int errors = 0;
   int checks = 0;
   int exp_ptr = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_prio_arbiter #(.NCH(NCH)) uut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_i(mask_i),
      .ctrl_disable_i(ctrl_disable_i), .rotate_i(rotate_i), .hlda_i(hlda_i),
      .svc_done_i(svc_done_i), .hold_req_o(hold_req_o), .grant_o(grant_o),
      .grant_id_o(grant_id_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int model_win(input logic [3:0] el, input int top);
      for (int k = 0; k < NCH; k++) begin
         if (el[(top + k) % NCH]) return (top + k) % NCH;
      end
      return -1;
   endfunction

   // one complete handshake; returns served channel or -1
   task automatic serve(input logic [3:0] rq, input logic [3:0] mk,
                        input bit dis, input bit rot, output int got);
      logic [3:0] el;
      int exp_w;
      el = dis ? 4'h0 : (rq & ~mk);
      exp_w = model_win(el, rot ? exp_ptr : 0);
      got = -1;
      req_i = rq; mask_i = mk; ctrl_disable_i = dis; rotate_i = rot;
      @(negedge clk);
      if (el == 4'h0) begin
         check(hold_req_o == 1'b0, dis ? "R4 disabled no hold" : "R3 masked no hold",
               int'(hold_req_o), 0);
         @(negedge clk);
         check(hold_req_o == 1'b0, "R3/R4 still no hold", int'(hold_req_o), 0);
         req_i = '0; ctrl_disable_i = 1'b0;
         @(negedge clk);
         return;
      end
      check(hold_req_o == 1'b1, "R2 hold raised", int'(hold_req_o), 1);
      check(grant_o == '0, "R7 no grant before hlda", int'(grant_o), 0);
      hlda_i = 1'b1;
      @(negedge clk);
      check(grant_o == 4'(1 << exp_w), rot ? "R6 rotating winner" : "R5 fixed winner",
            int'(grant_o), 1 << exp_w);
      check(int'(grant_id_o) == exp_w, "R7 grant id", int'(grant_id_o), exp_w);
      got = int'(grant_id_o);
      // perturb everything during service
      req_i = ~rq; mask_i = ~mk; ctrl_disable_i = ~dis; rotate_i = ~rot;
      @(negedge clk);
      check(grant_o == 4'(1 << exp_w) && hold_req_o, "R8 grant locked",
            int'(grant_o), 1 << exp_w);
      rotate_i = rot; svc_done_i = 1'b1;
      @(negedge clk);
      svc_done_i = 1'b0;
      check(grant_o == '0 && !hold_req_o, "R9 release", int'({hold_req_o, grant_o}), 0);
      exp_ptr = rot ? (exp_w + 1) % NCH : 0;
      req_i = 4'hF; mask_i = '0; ctrl_disable_i = 1'b0;
      @(negedge clk);
      check(hold_req_o == 1'b0, "R9 no hold while hlda high", int'(hold_req_o), 0);
      hlda_i = 1'b0; req_i = '0;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (60000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      int got;
      int since3;
      repeat (3) @(negedge clk);
      check(hold_req_o == 1'b0 && grant_o == '0 && grant_id_o == '0, "R1 reset state",
            int'({hold_req_o, grant_o, grant_id_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1/R10: pointer starts at channel 0 in rotating mode
      serve(4'hF, 4'h0, 1'b0, 1'b1, got);
      check(got == 0, "R1 pointer reset to channel 0", got, 0);

      // R10: after rotating service of 0 then 1, fixed mode still picks 0
      serve(4'hF, 4'h0, 1'b0, 1'b1, got);
      check(got == 1, "R6 rotate advances", got, 1);
      serve(4'hF, 4'h0, 1'b0, 1'b0, got);
      check(got == 0, "R10 fixed after rotating", got, 0);
      serve(4'hF, 4'h0, 1'b0, 1'b1, got);
      check(got == 0, "R10 fixed service reset pointer", got, 0);

      // exhaustive sweep of mode, request and mask
      for (int rot = 0; rot < 2; rot++) begin
         for (int rq = 1; rq < 16; rq++) begin
            for (int mk = 0; mk < 16; mk++) begin
               serve(4'(rq), 4'(mk), 1'b0, rot[0], got);
            end
         end
      end

      // R4: disable blocks every request pattern
      for (int rq = 1; rq < 16; rq++) begin
         serve(4'(rq), 4'h0, 1'b1, 1'b0, got);
      end

      // R11: fairness with all channels requesting
      exp_ptr = 0;
      serve(4'hF, 4'h0, 1'b0, 1'b0, got);
      since3 = 0;
      for (int n = 0; n < 12; n++) begin
         serve(4'hF, 4'h0, 1'b0, 1'b1, got);
         if (got == 3) since3 = 0; else since3++;
         check(since3 <= 3, "R11 channel 3 waits at most three services", since3, 3);
      end

      // R12: request withdrawn before acknowledge
      req_i = 4'b0100; mask_i = '0;
      @(negedge clk);
      check(hold_req_o == 1'b1, "R2 hold raised before withdraw", int'(hold_req_o), 1);
      req_i = '0; hlda_i = 1'b1;
      @(negedge clk);
      check(hold_req_o == 1'b0 && grant_o == '0, "R12 withdraw drops hold",
            int'({hold_req_o, grant_o}), 0);
      hlda_i = 1'b0;
      @(negedge clk);
      check(hold_req_o == 1'b0, "R12 stays idle", int'(hold_req_o), 0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule